// File: doc/BRIEF.md
# Packet Page Allocator With Queues

This block looks after a small pool of fixed-size packet pages in a network controller. An allocation bitmask records which pages are in use. Three short queues of page numbers sit beside it: frames received and waiting for software, frames queued for transmission, and transmitted frames waiting for software to acknowledge them. Software drives the block through a one-byte command. The receive path asks for a page with a request line. An external sender takes queued transmit pages through a valid/ready handshake. The default build has four pages and queues four entries deep.

An allocation for transmit that finds no free page does not fail for good. It stays pending and completes by itself in the first cycle a page is free again. A failed allocation, and a read of an empty queue head, both return the code 0x80. Moving frame data, computing the CRC and driving the line all belong to other blocks.

Top module: `pkt_page_alloc`

## Requirements
- R1: A command is accepted when `cmd_valid` is high, and its code is `cmd_byte[7:5]`. Bits 4:0 are ignored. Code 0 changes nothing.
- R2: Code 1 (allocate for transmit) first clears `alloc_done`, then takes the lowest-numbered free page. On success `alloc_result` is that page number and `alloc_done` is set. If no page is free, `alloc_result` is 0x80.
- R3: A failed code-1 allocation stays pending. In the first cycle that a page is free after the same-cycle releases, the allocation completes: `alloc_result` takes the lowest free page and `alloc_done` is set.
- R4: Code 2 clears the bitmask, all three queues, the pending allocation and `alloc_result` (to 0x00). A receive request in the same cycle is refused.
- R5: `rx_head_code` and `cmp_head_code` give the head page number of their queue, or 0x80 when the queue is empty.
- R6: Code 3 pops the receive queue. Code 4 releases the receive head page and then pops it. Both do nothing on an empty queue. `rx_ready` is high exactly while the receive queue holds an entry.
- R7: Code 5 releases the page whose number is on `pkt_num`.
- R8: Code 6 appends `pkt_num` to the transmit queue. It is ignored if the queue held 4 entries at the start of the cycle. `tx_send_valid` is high only while `tx_enable` is high and the queue is non-empty, and it offers the head page. A cycle with both valid and ready removes the head.
- R9: When a page is handed to the sender, it is freed if `auto_release` is high. Otherwise it is appended to the completion queue, provided that queue held fewer than 4 entries at the start of the cycle; if it did not, the page stays allocated. `cmp_pop` removes a completion entry that was present at the start of the cycle.
- R10: Code 7 empties the transmit and completion queues and leaves the bitmask unchanged.
- R11: A receive request is granted in the same cycle, on `rx_grant`, when a page is free and the receive queue held fewer than 4 entries. It takes the lowest free page and appends it to the receive queue. Otherwise it is refused.
- R12: `used_count` is the number of allocated pages.
- R13: Within one cycle the effects apply in this order: send handshake, command, completion pop, pending allocation retry, receive request. A retry therefore takes a freed page ahead of a receive request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_byte | input | 8 | Command byte; code in bits 7:5 |
| pkt_num | input | 2 | Page number used by release and enqueue |
| tx_enable | input | 1 | Allows transmit dispatch |
| auto_release | input | 1 | Free pages on dispatch instead of queuing a completion |
| rx_req | input | 1 | Receive path asks for a page |
| rx_grant | output | 1 | Receive request granted this cycle |
| tx_send_valid | output | 1 | A transmit page is offered |
| tx_send_page | output | 2 | Offered page number |
| tx_send_ready | input | 1 | Sender takes the offered page |
| cmp_pop | input | 1 | Acknowledge completion queue head |
| alloc_result | output | 8 | Last allocation result, 0x80 on failure |
| rx_head_code | output | 8 | Receive queue head or 0x80 |
| cmp_head_code | output | 8 | Completion queue head or 0x80 |
| used_count | output | 3 | Number of allocated pages |
| alloc_done | output | 1 | Transmit allocation completed |
| rx_ready | output | 1 | Receive queue not empty |
| tx_idle | output | 1 | Transmit queue empty |
| cmp_ready | output | 1 | Completion queue not empty |

## Verification
On every cycle the assertions check these points. A pending allocation only exists while every page is in use. A full pool refuses a receive request when no release can happen in that cycle. A disabled transmitter never shrinks its queue. A full queue holds its count against a lone push. A reset command leaves the pool empty one cycle later. They also check that `alloc_done` only rises together with a real page number. The priorities within a cycle can only be shown by the bench's scenarios and its per-cycle model: a retry winning a freed page over a receive request, the lowest-page choice, completion overflow and the interplay of pops with pushes.

// File: rtl/pkt_alloc_pkg.sv
package pkt_alloc_pkg;

  typedef enum logic [2:0] {
    CMD_NOP         = 3'd0,
    CMD_TX_ALLOC    = 3'd1,
    CMD_RESET_ALL   = 3'd2,
    CMD_RX_POP      = 3'd3,
    CMD_RX_FREE_POP = 3'd4,
    CMD_RELEASE     = 3'd5,
    CMD_TX_ENQ      = 3'd6,
    CMD_TX_CLEAR    = 3'd7
  } mmu_cmd_e;

  localparam logic [7:0] NO_PAGE = 8'h80;

endpackage

// File: rtl/alloc_rst_sync.sv
module alloc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/page_queue.sv
module page_queue #(
  parameter int DEPTH = 4,
  parameter int DW    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       pop,
  input  logic                       push,
  input  logic [DW-1:0]              push_data,
  output logic [DW-1:0]              head,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] ent_q [DEPTH];
  logic [DW-1:0] ent_d [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          do_pop;
  logic          do_push;
  logic          upd_en;

  // Pop only what was present at the start of the cycle; push only into room that existed then.
  assign do_pop  = pop && (cnt_q != '0);
  assign do_push = push && (cnt_q < CW'(DEPTH));
  assign upd_en  = do_pop || do_push || clr;

  always_comb begin
    logic [CW-1:0] mid;
    for (int i = 0; i < DEPTH; i++) begin
      ent_d[i] = ent_q[i];
    end
    mid = cnt_q;
    if (do_pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        ent_d[i] = ent_q[i + 1];
      end
      mid = cnt_q - 1'b1;
    end
    cnt_d = mid;
    if (do_push) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) == mid) begin
          ent_d[i] = push_data;
        end
      end
      cnt_d = mid + 1'b1;
    end
    if (clr) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ent_q[i] <= '0;
      end
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) begin
        ent_q[i] <= ent_d[i];
      end
    end
  end

  assign head  = ent_q[0];
  assign count = cnt_q;

  AST_Q_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH))
    else $error("queue count beyond depth"); // R5

  AST_Q_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH) && push && !pop && !clr) |=> (cnt_q == CW'(DEPTH)))
    else $error("push on full queue changed count"); // R8

endmodule

// File: rtl/page_count.sv
module page_count #(
  parameter int N = 4
) (
  input  logic [N-1:0]           mask,
  output logic [$clog2(N+1)-1:0] used
);

  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] part [N+1];

  assign part[0] = '0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_add
      assign part[g+1] = part[g] + CW'(mask[g]);
    end
  endgenerate

  assign used = part[N];

endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
  import pkt_alloc_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int QDEPTH    = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_valid,
  input  logic [7:0]                     cmd_byte,
  input  logic [$clog2(NUM_PAGES)-1:0]   pkt_num,
  input  logic                           tx_enable,
  input  logic                           auto_release,
  input  logic                           rx_req,
  output logic                           rx_grant,
  output logic                           tx_send_valid,
  output logic [$clog2(NUM_PAGES)-1:0]   tx_send_page,
  input  logic                           tx_send_ready,
  input  logic                           cmp_pop,
  output logic [7:0]                     alloc_result,
  output logic [7:0]                     rx_head_code,
  output logic [7:0]                     cmp_head_code,
  output logic [$clog2(NUM_PAGES+1)-1:0] used_count,
  output logic                           alloc_done,
  output logic                           rx_ready,
  output logic                           tx_idle,
  output logic                           cmp_ready
);

  localparam int PW  = $clog2(NUM_PAGES);
  localparam int QCW = $clog2(QDEPTH + 1);

  logic                 rst_sync_n;
  mmu_cmd_e             cmd;
  logic                 unused_low_bits;

  logic [NUM_PAGES-1:0] mask_q, mask_d;
  logic [7:0]           res_q, res_d;
  logic                 pend_q, pend_d;
  logic                 done_q, done_d;
  logic                 st_en;
  logic                 tx_fire;
  logic                 wipe_all;

  logic                 rx_clr, rx_pop, rx_push;
  logic [PW-1:0]        rx_data, rx_head;
  logic [QCW-1:0]       rx_cnt;
  logic                 tx_clr, tx_pop, tx_push;
  logic [PW-1:0]        tx_data, tx_head;
  logic [QCW-1:0]       tx_cnt;
  logic                 c_clr, c_pop, c_push;
  logic [PW-1:0]        c_data, c_head;
  logic [QCW-1:0]       c_cnt;

  // {found, index} of the lowest clear bit
  function automatic logic [PW:0] lowest_free(input logic [NUM_PAGES-1:0] mm);
    logic [PW:0] r;
    r = '0;
    for (int i = NUM_PAGES - 1; i >= 0; i--) begin
      if (!mm[i]) begin
        r = {1'b1, PW'(i)};
      end
    end
    return r;
  endfunction

  alloc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign cmd             = mmu_cmd_e'(cmd_byte[7:5]);
  assign unused_low_bits = ^cmd_byte[4:0];
  assign wipe_all        = cmd_valid && (cmd == CMD_RESET_ALL);
  assign tx_send_valid   = tx_enable && (tx_cnt != '0);
  assign tx_send_page    = tx_head;
  assign tx_fire         = tx_send_valid && tx_send_ready;
  assign st_en           = cmd_valid || tx_fire || rx_req || cmp_pop || pend_q;

  // Next-state: dispatch, command, completion pop, retry, receive (R13)
  always_comb begin
    logic [PW:0] pick;
    pick     = '0;
    mask_d   = mask_q;
    res_d    = res_q;
    pend_d   = pend_q;
    done_d   = done_q;
    rx_clr   = 1'b0;
    rx_pop   = 1'b0;
    rx_push  = 1'b0;
    rx_data  = '0;
    tx_clr   = 1'b0;
    tx_pop   = 1'b0;
    tx_push  = 1'b0;
    tx_data  = pkt_num;
    c_clr    = 1'b0;
    c_pop    = 1'b0;
    c_push   = 1'b0;
    c_data   = tx_head;
    rx_grant = 1'b0;

    // send handshake
    if (tx_fire) begin
      tx_pop = 1'b1;
      if (auto_release) begin
        mask_d[tx_head] = 1'b0;
      end else begin
        c_push = 1'b1;
      end
    end

    // command
    if (cmd_valid) begin
      unique case (cmd)
        CMD_NOP: begin
        end
        CMD_TX_ALLOC: begin
          done_d = 1'b0;
          pick   = lowest_free(mask_d);
          if (pick[PW]) begin
            mask_d[pick[PW-1:0]] = 1'b1;
            res_d  = 8'(pick[PW-1:0]);
            done_d = 1'b1;
            pend_d = 1'b0;
          end else begin
            res_d  = NO_PAGE;
            pend_d = 1'b1;
          end
        end
        CMD_RESET_ALL: begin
          mask_d = '0;
          rx_clr = 1'b1;
          tx_clr = 1'b1;
          c_clr  = 1'b1;
          res_d  = 8'h00;
          pend_d = 1'b0;
        end
        CMD_RX_POP: begin
          rx_pop = 1'b1;
        end
        CMD_RX_FREE_POP: begin
          if (rx_cnt != '0) begin
            mask_d[rx_head] = 1'b0;
          end
          rx_pop = 1'b1;
        end
        CMD_RELEASE: begin
          mask_d[pkt_num] = 1'b0;
        end
        CMD_TX_ENQ: begin
          tx_push = 1'b1;
        end
        CMD_TX_CLEAR: begin
          tx_clr = 1'b1;
          c_clr  = 1'b1;
        end
      endcase
    end

    // completion acknowledge
    c_pop = cmp_pop;

    // pending transmit allocation retried after releases
    if (pend_d) begin
      pick = lowest_free(mask_d);
      if (pick[PW]) begin
        mask_d[pick[PW-1:0]] = 1'b1;
        res_d  = 8'(pick[PW-1:0]);
        done_d = 1'b1;
        pend_d = 1'b0;
      end
    end

    // receive-side request last
    if (rx_req && !wipe_all && (rx_cnt < QCW'(QDEPTH))) begin
      pick = lowest_free(mask_d);
      if (pick[PW]) begin
        mask_d[pick[PW-1:0]] = 1'b1;
        rx_push  = 1'b1;
        rx_data  = pick[PW-1:0];
        rx_grant = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mask_q <= '0;
      res_q  <= 8'h00;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else if (st_en) begin
      mask_q <= mask_d;
      res_q  <= res_d;
      pend_q <= pend_d;
      done_q <= done_d;
    end
  end

  page_queue #(.DEPTH(QDEPTH), .DW(PW)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (rx_clr),
    .pop       (rx_pop),
    .push      (rx_push),
    .push_data (rx_data),
    .head      (rx_head),
    .count     (rx_cnt)
  );

  page_queue #(.DEPTH(QDEPTH), .DW(PW)) u_txq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (tx_clr),
    .pop       (tx_pop),
    .push      (tx_push),
    .push_data (tx_data),
    .head      (tx_head),
    .count     (tx_cnt)
  );

  page_queue #(.DEPTH(QDEPTH), .DW(PW)) u_cmpq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (c_clr),
    .pop       (c_pop),
    .push      (c_push),
    .push_data (c_data),
    .head      (c_head),
    .count     (c_cnt)
  );

  page_count #(.N(NUM_PAGES)) u_cnt (
    .mask (mask_q),
    .used (used_count)
  );

  assign alloc_result  = res_q;
  assign alloc_done    = done_q;
  assign rx_head_code  = (rx_cnt == '0) ? NO_PAGE : 8'(rx_head);
  assign cmp_head_code = (c_cnt == '0) ? NO_PAGE : 8'(c_head);
  assign rx_ready      = (rx_cnt != '0);
  assign tx_idle       = (tx_cnt == '0);
  assign cmp_ready     = (c_cnt != '0);

  AST_PEND_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pend_q |-> (&mask_q))
    else $error("allocation pending with a free page"); // R3

  AST_FULL_REFUSES_RX: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((&mask_q) && !cmd_valid && !tx_fire) |-> !rx_grant)
    else $error("receive granted from a full pool"); // R11

  AST_TX_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!tx_enable && !cmd_valid) |=> (tx_cnt >= $past(tx_cnt)))
    else $error("transmit queue drained while disabled"); // R8

  AST_RESET_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid && cmd_byte[7:5] == 3'd2) |=>
      (used_count == '0 && alloc_result == 8'h00 && !rx_ready && tx_idle && !cmp_ready))
    else $error("reset command left state behind"); // R4

  AST_DONE_HAS_PAGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(done_q) |-> (res_q != NO_PAGE))
    else $error("allocation done without a page"); // R2

endmodule

// File: tb/sim_pkt_page_alloc.sv
module sim_pkt_page_alloc;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int QD = 4;

  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic [7:0] cmd_byte;
  logic [1:0] pkt_num;
  logic       tx_enable;
  logic       auto_release;
  logic       rx_req;
  logic       rx_grant;
  logic       tx_send_valid;
  logic [1:0] tx_send_page;
  logic       tx_send_ready;
  logic       cmp_pop;
  logic [7:0] alloc_result;
  logic [7:0] rx_head_code;
  logic [7:0] cmp_head_code;
  logic [2:0] used_count;
  logic       alloc_done;
  logic       rx_ready;
  logic       tx_idle;
  logic       cmp_ready;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  bit last_grant;

  // reference model state
  bit [NP-1:0] mm;
  int rxq[$];
  int txq[$];
  int cq[$];
  int mres;
  bit mpend;
  bit mdone;

  pkt_page_alloc #(.NUM_PAGES(NP), .QDEPTH(QD)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_byte      (cmd_byte),
    .pkt_num       (pkt_num),
    .tx_enable     (tx_enable),
    .auto_release  (auto_release),
    .rx_req        (rx_req),
    .rx_grant      (rx_grant),
    .tx_send_valid (tx_send_valid),
    .tx_send_page  (tx_send_page),
    .tx_send_ready (tx_send_ready),
    .cmp_pop       (cmp_pop),
    .alloc_result  (alloc_result),
    .rx_head_code  (rx_head_code),
    .cmp_head_code (cmp_head_code),
    .used_count    (used_count),
    .alloc_done    (alloc_done),
    .rx_ready      (rx_ready),
    .tx_idle       (tx_idle),
    .cmp_ready     (cmp_ready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lowest(input bit [NP-1:0] v);
    for (int i = 0; i < NP; i++) begin
      if (!v[i]) return i;
    end
    return -1;
  endfunction

  function automatic int ones(input bit [NP-1:0] v);
    int n = 0;
    for (int i = 0; i < NP; i++) n += v[i];
    return n;
  endfunction

  task automatic check_regs();
    chk("R2 alloc_result", alloc_result, mres);
    chk("R2 alloc_done", alloc_done, mdone);
    chk("R5 rx_head_code", rx_head_code, (rxq.size() > 0) ? rxq[0] : 128);
    chk("R5 cmp_head_code", cmp_head_code, (cq.size() > 0) ? cq[0] : 128);
    chk("R12 used_count", used_count, ones(mm));
    chk("R6 rx_ready", rx_ready, rxq.size() > 0);
    chk("R8 tx_idle", tx_idle, txq.size() == 0);
    chk("R9 cmp_ready", cmp_ready, cq.size() > 0);
  endtask

  // Called at a falling edge: drive, check same-cycle outputs, clock, update model, check registers.
  task automatic step(input bit cv, input int code, input int pk, input bit ten, input bit ar,
                      input bit rq, input bit rdy, input bit cp);
    bit [NP-1:0] nm;
    int nrx[$];
    int ntx[$];
    int nc[$];
    int nres;
    bit npend;
    bit ndone;
    int csz0;
    int txsz0;
    int rxsz0;
    int idx;
    bit exp_valid;
    bit exp_grant;
    bit fire;
    int p;
    cmd_valid     = cv;
    cmd_byte      = {code[2:0], 5'($urandom)};
    pkt_num       = pk[1:0];
    tx_enable     = ten;
    auto_release  = ar;
    rx_req        = rq;
    tx_send_ready = rdy;
    cmp_pop       = cp;
    #1;
    nm = mm; nrx = rxq; ntx = txq; nc = cq;
    nres = mres; npend = mpend; ndone = mdone;
    csz0 = cq.size(); txsz0 = txq.size(); rxsz0 = rxq.size();
    exp_valid = ten && (txq.size() > 0);
    fire = exp_valid && rdy;
    chk("R8 tx_send_valid", tx_send_valid, exp_valid);
    if (exp_valid) chk("R8 tx_send_page", tx_send_page, txq[0]);
    if (fire) begin
      p = ntx.pop_front();
      if (ar) nm[p] = 1'b0;
      else if (csz0 < QD) nc.push_back(p);
    end
    if (cv) begin
      case (code)
        1: begin
          ndone = 1'b0;
          idx = lowest(nm);
          if (idx >= 0) begin nm[idx] = 1'b1; nres = idx; ndone = 1'b1; npend = 1'b0; end
          else begin nres = 128; npend = 1'b1; end
        end
        2: begin
          nm = '0; nrx.delete(); ntx.delete(); nc.delete(); nres = 0; npend = 1'b0;
        end
        3: if (nrx.size() > 0) void'(nrx.pop_front());
        4: if (nrx.size() > 0) begin nm[nrx[0]] = 1'b0; void'(nrx.pop_front()); end
        5: nm[pk] = 1'b0;
        6: if (txsz0 < QD) ntx.push_back(pk);
        7: begin ntx.delete(); nc.delete(); end
        default: ;
      endcase
    end
    if (cp && csz0 > 0 && nc.size() > 0) void'(nc.pop_front());
    if (npend) begin
      idx = lowest(nm);
      if (idx >= 0) begin nm[idx] = 1'b1; nres = idx; ndone = 1'b1; npend = 1'b0; end
    end
    exp_grant = 1'b0;
    if (rq && !(cv && code == 2) && rxsz0 < QD) begin
      idx = lowest(nm);
      if (idx >= 0) begin nm[idx] = 1'b1; nrx.push_back(idx); exp_grant = 1'b1; end
    end
    chk("R11 rx_grant", rx_grant, exp_grant);
    last_grant = rx_grant;
    @(posedge clk);
    mm = nm; rxq = nrx; txq = ntx; cq = nc;
    mres = nres; mpend = npend; mdone = ndone;
    @(negedge clk);
    check_regs();
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 0; cmd_byte = 0; pkt_num = 0; tx_enable = 0; auto_release = 0;
    rx_req = 0; tx_send_ready = 0; cmp_pop = 0;
    mm = '0; mres = 0; mpend = 0; mdone = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R4 reset alloc_result", alloc_result, 0);
    chk("R5 reset rx head", rx_head_code, 8'h80);
    chk("R5 reset cmp head", cmp_head_code, 8'h80);
    chk("R12 reset used", used_count, 0);
    chk("R8 reset tx_idle", tx_idle, 1);

    // R2: lowest free page in order
    for (int i = 0; i < NP; i++) begin
      step(1, 1, 0, 0, 0, 0, 0, 0);
      chk("R2 lowest page", alloc_result, i);
      chk("R2 done", alloc_done, 1);
    end
    // R3: failure goes pending
    step(1, 1, 0, 0, 0, 0, 0, 0);
    chk("R3 fail code", alloc_result, 8'h80);
    chk("R3 done cleared", alloc_done, 0);
    // R11: full pool refuses
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R11 full refuse", last_grant, 0);
    // R7 + R3: release page 2 completes pending
    step(1, 5, 2, 0, 0, 0, 0, 0);
    chk("R3 retry page", alloc_result, 2);
    chk("R3 retry done", alloc_done, 1);
    chk("R7 used", used_count, 4);
    // R11: release 0 and receive together
    step(1, 5, 0, 0, 0, 1, 0, 0);
    chk("R11 grant", last_grant, 1);
    chk("R11 rx head", rx_head_code, 0);
    // R13: retry beats receive request for freed page
    step(1, 1, 0, 0, 0, 0, 0, 0);
    step(1, 5, 1, 0, 0, 1, 0, 0);
    chk("R13 retry wins", alloc_result, 1);
    chk("R13 rx refused", last_grant, 0);
    // R6: release and pop, then pop on empty
    step(1, 4, 0, 0, 0, 0, 0, 0);
    chk("R6 rx empty", rx_ready, 0);
    chk("R6 freed", used_count, 3);
    step(1, 3, 0, 0, 0, 0, 0, 0);
    chk("R6 empty pop", used_count, 3);
    // R8: enqueue while disabled
    step(1, 6, 1, 0, 0, 0, 1, 0);
    chk("R8 queued", tx_idle, 0);
    chk("R8 held", tx_send_valid, 0);
    // R9: dispatch to completion queue
    step(0, 0, 0, 1, 0, 0, 1, 0);
    chk("R9 cmp head", cmp_head_code, 1);
    chk("R9 tx drained", tx_idle, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R9 cmp popped", cmp_head_code, 8'h80);
    // R9: auto release
    step(1, 6, 2, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 0, 1, 0);
    chk("R9 auto freed", used_count, 2);
    chk("R9 no completion", cmp_ready, 0);
    // R8: fifth enqueue ignored
    for (int i = 0; i < 5; i++) step(1, 6, 3, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0, 1, 0);
    chk("R8 full ignored", tx_idle, 1);
    // R9: completion overflow drops entry
    step(1, 6, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 1, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R9 overflow dropped", cmp_ready, 0);
    chk("R9 overflow page kept", used_count, 2);
    // R10: clear transmit queues
    step(1, 6, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 1, 0);
    step(1, 6, 3, 0, 0, 0, 0, 0);
    step(1, 7, 0, 0, 0, 0, 0, 0);
    chk("R10 tx cleared", tx_idle, 1);
    chk("R10 cmp cleared", cmp_ready, 0);
    chk("R10 pages kept", used_count, 2);
    // R4: reset all refuses same-cycle receive
    step(1, 2, 0, 0, 0, 1, 0, 0);
    chk("R4 used", used_count, 0);
    chk("R4 result", alloc_result, 0);
    chk("R4 rx refused", last_grant, 0);
    // R1: code 0 with noisy low bits
    step(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 nop", used_count, 0);
    idle();

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      step($urandom_range(0, 2) == 0, $urandom_range(0, 7), $urandom_range(0, 3),
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 2) == 0,
           $urandom_range(0, 1), $urandom_range(0, 3) == 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule